// File: doc/BRIEF.md
# Flat Nested Table Page Walker

This block turns a guest virtual address into a system physical address for a virtual machine. The guest keeps its own four-level radix page table, and each pointer in it is a guest physical address. The hypervisor's nested translation is one linear array of 8-byte entries, indexed directly by guest physical page number. Each guest physical pointer therefore costs a single lookup in that array. A full translation takes nine memory reads: one nested lookup for the guest root, one guest read per level with a nested lookup after each, and the last lookup on the data page.

The walker takes a start pulse together with the guest root, the nested root and the guest virtual address. It issues reads one at a time on a simple memory port and waits for each response before the next one. When it finishes it pulses `done` with either the translated address or a fault. A guest page number outside the configured VM size faults without a read. An entry with its present bit clear faults with no further reads.

Top module: `flat_nested_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low. `mem_req` is never high while `busy` is low.
- R2: The first read goes to `nest_root + 8 * guest_root[31:12]`. The low 12 bits of `guest_root` are ignored.
- R3: The guest-level reads, in order L4, L3, L2, L1, go to `{frame, 12'h000} + 8 * idx`. Here `frame` comes from the preceding nested lookup, and `idx` is `gva[47:39]`, `gva[38:30]`, `gva[29:21]` or `gva[20:12]`.
- R4: Nested lookups and guest-level reads alternate, starting and ending with a nested lookup. The frame from each guest entry is looked up at `nest_root + 8 * frame`. A translation without a fault issues exactly 9 reads.
- R5: Every entry is 64 bits. Bit 0 is the present bit and bits 51:12 hold the page frame number. All other bits are ignored.
- R6: On success `done` is high for exactly one cycle with `fault` low and `spa = {final frame, gva[11:0]}`.
- R7: A response with bit 0 clear ends the walk with `fault` high and `spa` zero, and no further read is issued.
- R8: A guest page number at or above `VM_PAGES` ends the walk with `fault` high and `spa` zero, and no nested read is issued for it.
- R9: At most one read is outstanding. `mem_req` is not raised again until `mem_rvalid` has answered the previous request.
- R10: `start` and the request inputs are ignored while `busy` is high. The walk in progress completes with the values captured at its start.
- R11: `busy` rises the cycle after an accepted `start`, stays high through the `done` cycle, and falls the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when not busy) |
| guest_root | input | GPA_W | Guest physical address of the top guest table |
| nest_root | input | PA_W | System physical base of the flat nested table |
| gva | input | 48 | Guest virtual address to translate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (valid with done) |
| spa | output | PA_W | Translated system physical address (valid with done) |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | PA_W | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The hardest cases to reach are the faults partway through the walk: a missing entry at a chosen level, or a guest entry that points outside the VM. Both need specific memory contents at exactly one address on the walk path. The bench builds its memory arithmetically with a 16-page VM. Per run it can mark one nested entry absent, one guest table absent, or one guest table whose entries all point past the VM size. It sweeps each of these over every page, so every position in the nine-reference order gets a fault. Start pulses with different inputs are also injected while reads are still pending.

// File: rtl/fnw_pkg.sv
// Shared constants and types for the flat nested table walker.
// Assumes 4 KiB pages, 8-byte entries and a four-level guest radix tree.
package fnw_pkg;
    localparam int PAGE_SHIFT  = 12;
    localparam int IDX_W       = 9;
    localparam int LEVELS      = 4;
    localparam int ENTRY_SHIFT = 3;
    localparam int PTE_W       = 64;
    localparam int NUM_REFS    = 2 * LEVELS + 1;
    localparam int VA_W        = PAGE_SHIFT + IDX_W * LEVELS;
    localparam int STEP_W      = $clog2(NUM_REFS);
    localparam int LVL_W       = $clog2(LEVELS);

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2,
        WS_DONE  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/fnw_pte_decode.sv
// Splits a 64-bit table entry into its present bit and page frame number.
// Assumes present at bit 0 and the frame in bits PA_W-1:12; other bits are ignored.
module fnw_pte_decode
    import fnw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [PTE_W-1:0]           entry,
    output logic                       present,
    output logic [PA_W-PAGE_SHIFT-1:0] frame
);
    logic unused_bits;

    // Field extraction
    assign present     = entry[0];
    assign frame       = entry[PA_W-1:PAGE_SHIFT];
    assign unused_bits = ^{entry[PTE_W-1:PA_W], entry[PAGE_SHIFT-1:1]};
endmodule

// File: rtl/fnw_range_chk.sv
// Flags whether a guest physical page number lies inside the configured VM size.
// Assumes VM_PAGES fits in 64 bits and FRAME_W is at most 64.
module fnw_range_chk #(
    parameter int          FRAME_W  = 40,
    parameter int unsigned VM_PAGES = 1 << 20
) (
    input  logic [FRAME_W-1:0] gpn,
    output logic               in_range
);
    logic [63:0] gpn_ext;

    // Unsigned compare against the page limit
    assign gpn_ext  = {{(64-FRAME_W){1'b0}}, gpn};
    assign in_range = gpn_ext < 64'(VM_PAGES);
endmodule

// File: rtl/fnw_addr_gen.sv
// Produces the read address for the current reference step.
// Even steps are flat nested lookups, odd steps are guest-level reads.
// Assumes step 1 is level L4 and step 7 is level L1.
module fnw_addr_gen
    import fnw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [STEP_W-1:0]          step,
    input  logic [VA_W-1:0]            gva,
    input  logic [PA_W-1:0]            nest_root,
    input  logic [PA_W-PAGE_SHIFT-1:0] gpn,
    input  logic [PA_W-PAGE_SHIFT-1:0] frame,
    output logic [PA_W-1:0]            addr
);
    logic [IDX_W-1:0]  idx_tbl [LEVELS];
    logic [STEP_W-1:0] level;
    logic [IDX_W-1:0]  idx_sel;
    logic [PA_W-1:0]   nest_addr;
    logic [PA_W-1:0]   guest_addr;
    logic              unused_in;

    // One index field per guest level, top level first
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
        assign idx_tbl[lv] = gva[PAGE_SHIFT + IDX_W*(LEVELS-1-lv) +: IDX_W];
    end

    // Level select and the two address forms
    assign level      = step >> 1;
    assign idx_sel    = idx_tbl[level[LVL_W-1:0]];
    assign nest_addr  = nest_root + PA_W'({gpn, {ENTRY_SHIFT{1'b0}}});
    assign guest_addr = {frame, {PAGE_SHIFT{1'b0}}} + PA_W'({idx_sel, {ENTRY_SHIFT{1'b0}}});
    assign addr       = step[0] ? guest_addr : nest_addr;
    assign unused_in  = ^{gva[PAGE_SHIFT-1:0], level[STEP_W-1:LVL_W]};
endmodule

// File: rtl/flat_nested_walker.sv
// Two-dimensional page walker with a flat nested table.
// Issues nine reads per full translation with one read outstanding at a time.
// Faults on a clear present bit or on a guest page number at or above VM_PAGES.
// Assumes the memory answers every request with exactly one mem_rvalid pulse.
module flat_nested_walker
    import fnw_pkg::*;
#(
    parameter int          PA_W     = 52,
    parameter int          GPA_W    = 32,
    parameter int unsigned VM_PAGES = 1 << 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [GPA_W-1:0]   guest_root,
    input  logic [PA_W-1:0]    nest_root,
    input  logic [VA_W-1:0]    gva,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [PA_W-1:0]    spa,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [PTE_W-1:0]   mem_rdata
);
    localparam int FRAME_W = PA_W - PAGE_SHIFT;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_REFS - 1);

    walk_state_e          state_q;
    logic [STEP_W-1:0]    step_q;
    logic [VA_W-1:0]      gva_q;
    logic [PA_W-1:0]      nroot_q;
    logic [FRAME_W-1:0]   gpn_q;
    logic [FRAME_W-1:0]   frame_q;
    logic                 fault_q;
    logic [PA_W-1:0]      spa_q;
    logic                 rsp_present;
    logic [FRAME_W-1:0]   rsp_frame;
    logic                 gpn_ok;
    logic                 nested_step;
    logic                 unused_root;

    fnw_pte_decode #(.PA_W(PA_W)) pte_i (
        .entry   (mem_rdata),
        .present (rsp_present),
        .frame   (rsp_frame)
    );

    fnw_range_chk #(.FRAME_W(FRAME_W), .VM_PAGES(VM_PAGES)) rng_i (
        .gpn      (gpn_q),
        .in_range (gpn_ok)
    );

    fnw_addr_gen #(.PA_W(PA_W)) agen_i (
        .step      (step_q),
        .gva       (gva_q),
        .nest_root (nroot_q),
        .gpn       (gpn_q),
        .frame     (frame_q),
        .addr      (mem_addr)
    );

    // Output decode from the walk state
    assign nested_step = ~step_q[0];
    assign busy        = (state_q != WS_IDLE);
    assign done        = (state_q == WS_DONE);
    assign fault       = fault_q;
    assign spa         = spa_q;
    assign mem_req     = (state_q == WS_ISSUE) && (!nested_step || gpn_ok);
    assign unused_root = ^guest_root[PAGE_SHIFT-1:0];

    // Walk sequencer: capture request, step through references, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            step_q  <= '0;
            gva_q   <= '0;
            nroot_q <= '0;
            gpn_q   <= '0;
            frame_q <= '0;
            fault_q <= 1'b0;
            spa_q   <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (start) begin
                        gva_q   <= gva;
                        nroot_q <= nest_root;
                        gpn_q   <= FRAME_W'(guest_root[GPA_W-1:PAGE_SHIFT]);
                        step_q  <= '0;
                        fault_q <= 1'b0;
                        spa_q   <= '0;
                        state_q <= WS_ISSUE;
                    end
                end
                WS_ISSUE: begin
                    if (nested_step && !gpn_ok) begin
                        fault_q <= 1'b1;
                        state_q <= WS_DONE;
                    end else begin
                        state_q <= WS_WAIT;
                    end
                end
                WS_WAIT: begin
                    if (mem_rvalid) begin
                        if (!rsp_present) begin
                            fault_q <= 1'b1;
                            state_q <= WS_DONE;
                        end else if (step_q == LAST_STEP) begin
                            spa_q   <= {rsp_frame, gva_q[PAGE_SHIFT-1:0]};
                            state_q <= WS_DONE;
                        end else begin
                            if (step_q[0]) gpn_q <= rsp_frame;
                            else           frame_q <= rsp_frame;
                            step_q  <= step_q + 1'b1;
                            state_q <= WS_ISSUE;
                        end
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fnw_checker.sv
// Protocol checks on the walker ports, bound to every instance of the top.
module fnw_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fault,
    input logic mem_req,
    input logic mem_rvalid
);
    logic       pend_q;
    logic [4:0] refs_q;

    // Track an unanswered read
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mem_req)    pend_q <= 1'b1;
        else if (mem_rvalid) pend_q <= 1'b0;
    end

    // Count reads issued in the current walk
    always_ff @(posedge clk) begin
        if (!rst_n)                       refs_q <= '0;
        else if (start && !busy)          refs_q <= '0;
        else if (mem_req && refs_q != '1) refs_q <= refs_q + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R1
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !pend_q); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_NINE_REFS: assert property (@(posedge clk) disable iff (!rst_n) (done && !fault) |-> (refs_q == 5'd9)); // R4
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R11
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R11
endmodule

bind flat_nested_walker fnw_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid)
);

// File: tb/flat_nested_walker_tb_top.sv
`timescale 1ns/1ps
module flat_nested_walker_tb_top;
    localparam int VMP = 16;
    localparam logic [51:0] NROOT = 52'h0000123456000;
    localparam logic [39:0] BASEF = 40'h00000ABC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] guest_root = '0;
    logic [51:0] nest_root = '0;
    logic [47:0] gva = '0;
    logic        busy, done, fault, mem_req;
    logic [51:0] spa, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int vectors = 0;
    int misc = 0;
    int bad_ngpn = -1;
    int np_g = -1;
    int oor_g = -1;

    logic [51:0] exp_addr [16];
    int          exp_n;
    logic        exp_fault;
    logic [51:0] exp_spa;
    logic [51:0] got_addr [16];
    int          got_n;
    logic        got_fault;
    logic [51:0] got_spa;
    bit          hung;

    always #2.5 clk = ~clk;

    flat_nested_walker #(.PA_W(52), .GPA_W(32), .VM_PAGES(VMP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .guest_root(guest_root),
        .nest_root(nest_root), .gva(gva), .busy(busy), .done(done),
        .fault(fault), .spa(spa), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misc++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory image: nested table, 16 guest table pages, all else zero
    function automatic logic [63:0] memv(input logic [51:0] a);
        logic [39:0] f;
        int g, i, t;
        logic p;
        if (a >= NROOT && a < NROOT + 52'd128) begin
            g = int'((a - NROOT) >> 3);
            f = BASEF + 40'(g);
            p = (g != bad_ngpn);
            return {12'h000, f, 11'h000, p};
        end
        f = a[51:12];
        if (f >= BASEF && f < BASEF + 40'd16) begin
            g = int'(f - BASEF);
            i = int'(a[11:3]);
            t = (g == oor_g) ? (VMP + i) : ((g * 5 + i * 3 + 1) % VMP);
            p = (g != np_g);
            return {12'hFFF, 40'(t), 11'h7FF, p};
        end
        return 64'h0;
    endfunction

    // Reference walk from the requirements (R2..R8)
    task automatic model(input logic [31:0] groot, input logic [47:0] va);
        logic [39:0] gpn, fr;
        logic [63:0] e;
        logic [51:0] a;
        logic [8:0]  ix;
        exp_n = 0; exp_fault = 1'b0; exp_spa = '0;
        gpn = 40'(groot[31:12]);
        for (int lv = 0; lv <= 4; lv++) begin
            if (gpn >= 40'(VMP)) begin exp_fault = 1'b1; return; end
            a = NROOT + 52'({gpn, 3'b000});
            exp_addr[exp_n] = a; exp_n++;
            e = memv(a);
            if (!e[0]) begin exp_fault = 1'b1; return; end
            fr = e[51:12];
            if (lv == 4) begin exp_spa = {fr, va[11:0]}; return; end
            ix = va[39 - 9 * lv +: 9];
            a = {fr, 12'h000} + 52'({ix, 3'b000});
            exp_addr[exp_n] = a; exp_n++;
            e = memv(a);
            if (!e[0]) begin exp_fault = 1'b1; return; end
            gpn = e[51:12];
        end
    endtask

    // Drive one walk, serve reads with a given latency, record what happens
    task automatic run_walk(input logic [31:0] groot, input logic [47:0] va, input int lat, input bit poke);
        int cyc;
        got_n = 0; hung = 1'b0; cyc = 0;
        @(negedge clk);
        start = 1'b1; guest_root = groot; nest_root = NROOT; gva = va;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", 64'(busy), 64'd1);
        forever begin
            if (done) break;
            if (cyc > 300) begin hung = 1'b1; break; end
            if (mem_req) begin
                if (got_n < 16) got_addr[got_n] = mem_addr;
                got_n++;
                @(negedge clk); cyc++;
                for (int k = 0; k < lat; k++) begin
                    if (poke) begin
                        start = 1'b1; guest_root = ~groot; gva = ~va; nest_root = ~NROOT;
                    end
                    @(negedge clk); cyc++;
                end
                start = 1'b0; guest_root = groot; gva = va; nest_root = NROOT;
                mem_rvalid = 1'b1;
                mem_rdata = memv(got_addr[(got_n - 1) % 16]);
                @(negedge clk); cyc++;
                mem_rvalid = 1'b0;
            end else begin
                @(negedge clk); cyc++;
            end
        end
        got_fault = fault;
        got_spa = spa;
        if (hung) begin
            misc++; vectors++;
            $display("FAIL R6 actual=hung expected=done");
        end
        @(negedge clk);
        check(busy == 1'b0, "R11", 64'(busy), 64'd0);
    endtask

    task automatic compare(input string fault_tag, input string spa_tag);
        int n;
        n = (got_n < 16) ? got_n : 16;
        check(got_n == exp_n, "R4 R9 read count", 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < n; i++) begin
            if (i == 0)          check(got_addr[i] == exp_addr[i], "R2", 64'(got_addr[i]), 64'(exp_addr[i]));
            else if (i % 2 == 1) check(got_addr[i] == exp_addr[i], "R3", 64'(got_addr[i]), 64'(exp_addr[i]));
            else                 check(got_addr[i] == exp_addr[i], "R4", 64'(got_addr[i]), 64'(exp_addr[i]));
        end
        check(got_fault == exp_fault, fault_tag, 64'(got_fault), 64'(exp_fault));
        check(got_spa == exp_spa, spa_tag, 64'(got_spa), 64'(exp_spa));
    endtask

    function automatic logic [47:0] make_va(input int g, input int k);
        logic [8:0] i4, i3, i2, i1;
        i4 = 9'((k * 37 + g * 11) % 512);
        i3 = 9'((k * 101 + g) % 512);
        i2 = 9'((k * 59 + g * 3 + 7) % 512);
        i1 = 9'((k * 211 + g * 5) % 512);
        return {i4, i3, i2, i1, 12'((k * 293 + g) % 4096)};
    endfunction

    // Global watchdog
    initial begin
        #(200000 * 5);
        misc++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
        $finish;
    end

    initial begin
        logic [31:0] groot;
        logic [47:0] va;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", 64'(busy), 64'd0);
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        check(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);

        // R2..R6, R10: every root page with several addresses and latencies
        for (int g = 0; g < VMP; g++) begin
            for (int k = 0; k < 6; k++) begin
                groot = {12'h000, 8'(g), 12'((g * 97 + k) % 4096)};
                va = make_va(g, k);
                model(groot, va);
                run_walk(groot, va, k % 3, (k == 4));
                compare("R6", (k == 4) ? "R10" : "R6");
            end
        end

        // R7 and R5: missing nested entry at each page
        for (int b = 0; b < VMP; b++) begin
            bad_ngpn = b;
            for (int k = 0; k < 2; k++) begin
                groot = {12'h000, 8'((b + k * 3) % VMP), 12'h000};
                va = make_va(b, k + 10);
                model(groot, va);
                run_walk(groot, va, k, 1'b0);
                compare("R7", "R7");
            end
        end
        bad_ngpn = -1;

        // R7: missing guest table page
        for (int b = 0; b < VMP; b++) begin
            np_g = b;
            groot = {12'h000, 8'((b * 7) % VMP), 12'h000};
            va = make_va(b, 20);
            model(groot, va);
            run_walk(groot, va, 1, 1'b0);
            compare("R7", "R7");
        end
        np_g = -1;

        // R8: guest entries pointing past the VM size
        for (int b = 0; b < VMP; b++) begin
            oor_g = b;
            groot = {12'h000, 8'((b * 3 + 1) % VMP), 12'h000};
            va = make_va(b, 30);
            model(groot, va);
            run_walk(groot, va, 0, 1'b0);
            compare("R8", "R8");
        end
        oor_g = -1;

        // R8: guest root itself outside the VM
        for (int b = 0; b < 4; b++) begin
            groot = {12'h000, 8'(VMP + b * 5), 12'h000};
            va = make_va(b, 40);
            model(groot, va);
            run_walk(groot, va, 0, 1'b0);
            compare("R8", "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
        $finish;
    end
endmodule